// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sequences the low-power states of a small 8-bit microcontroller core. When the core strobes a sleep instruction, the block samples a mode-select bit and moves to one of two states. Deep sleep stops the oscillator and every clock. Idle stops only the core clock, so the oscillator and the peripherals keep running.

While the core is parked, the block watches the wake sources that apply to the current depth. It then tells the core how to come back. Resume-next means continue after the sleep instruction with all state kept. Service means take an interrupt with all state kept. Restart means a full reset to address zero.

A reset-pin assertion or a watchdog timeout always means restart, and it outranks every other source arriving in the same cycle. The wake pin is synchronized and acts on its falling edge, in deep sleep only. Interrupt requests act in idle only. The block also drives a watchdog-clear strobe after power-on reset and reports the current mode for observation.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is RUN (mode_o = 2'b00). In RUN, core_clk_en = 1, osc_en = 1 and periph_clk_en = 1, and reset_req, resume_next and irq_take are 0.
- R2: In RUN, sleep_exec = 1 with mode_sel = 0 enters IDLE (mode_o = 2'b01) on the next clock edge. In IDLE, core_clk_en = 0, osc_en = 1 and periph_clk_en = 1.
- R3: In RUN, sleep_exec = 1 with mode_sel = 1 enters SLEEP (mode_o = 2'b10) on the next clock edge. In SLEEP, core_clk_en, osc_en and periph_clk_en are all 0.
- R4: In SLEEP, a high-to-low transition on wake_pin_n returns the block to RUN and gives a one-cycle resume_next pulse. With SYNC_STAGES = 2, this happens on the third clock edge after the pin changes. A pin that stays high or stays low does not wake.
- R5: In any state, ext_rst_n = 0 or wdt_timeout = 1 at a clock edge causes reset_req = 1 and mode_o = RUN in the following cycle.
- R6: A restart condition (R5) seen in the same cycle as a wake-pin edge, an interrupt request or a sleep strobe wins. Only reset_req is produced, and the block ends in RUN.
- R7: In IDLE, if any irq_req bit is high and at least one requested line has its irq_en bit set, the block returns to RUN on the next edge. It pulses irq_take, and irq_id gives the lowest-numbered line that is both requested and enabled.
- R8: In IDLE, if irq_req bits are high but none of them has its irq_en bit set, the block returns to RUN on the next edge with a resume_next pulse and no irq_take.
- R9: In SLEEP, irq_req has no effect and the block stays in SLEEP. In IDLE, wake_pin_n has no effect and the block stays in IDLE.
- R10: sleep_exec has no effect outside RUN. A strobe in IDLE with mode_sel = 1 leaves the block in IDLE.
- R11: wdt_clear is 1 during power-on reset and returns to 0 on the first clock edge after rst_n is released.
- R12: At most one of reset_req, resume_next and irq_take is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sleep_exec | input | 1 | One-cycle strobe: core executed the sleep instruction |
| mode_sel | input | 1 | Depth select sampled with sleep_exec: 1 = SLEEP, 0 = IDLE |
| wake_pin_n | input | 1 | Asynchronous active-low external wake pin |
| ext_rst_n | input | 1 | Active-low external reset pin, synchronous to clk |
| wdt_timeout | input | 1 | Watchdog timeout indication |
| irq_req | input | NUM_IRQ | Pending interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enable bits |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| reset_req | output | 1 | Restart request to address zero |
| resume_next | output | 1 | Pulse: resume at the instruction after the sleep instruction |
| irq_take | output | 1 | Pulse: wake and service interrupt irq_id |
| irq_id | output | IDW | Index of the interrupt to service, valid with irq_take |
| wdt_clear | output | 1 | Watchdog and prescaler clear after power-on |
| mode_o | output | 2 | Current mode: 00 RUN, 01 IDLE, 10 SLEEP |

## Verification
The bench builds the block with NUM_IRQ = 4 and SYNC_STAGES = 2. Four lines are enough to place the requested and enabled lines at different indices, so the lowest-index choice and the requested-but-disabled path can both be exercised. Two synchronizer stages fix the wake latency at three edges. With that latency known, a watchdog timeout can be timed to land in exactly the cycle where the detected wake edge is presented, which tests the restart priority.

// File: rtl/pwr_mode_pkg.sv
// Package: shared types of the power-mode controller.
// Assumes: state encoding is visible at the mode_o port and must stay fixed.
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_NONE    = 2'b00,
        WK_RESTART = 2'b01,
        WK_RESUME  = 2'b10,
        WK_SERVICE = 2'b11
    } wake_act_e;

endpackage

// File: rtl/pwr_wake_sync.sv
// Module: pwr_wake_sync
// Brings the asynchronous active-low wake pin into the clock domain through
// a chain of STAGES flops and flags a high-to-low transition of the result.
// Assumes: the pin idles high; the flag is combinational and valid for one
// cycle after the synchronized level changes.
module pwr_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pin into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= pin_n;
                end
            end else begin : g_rest
                // Shift the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign fall = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/pwr_wake_arbiter.sv
// Module: pwr_wake_arbiter
// Combinational decision logic: from the current state and all event inputs,
// picks the next state, the action to report and the interrupt to service.
// Restart sources outrank everything; wake sources are filtered by depth.
// Assumes: ext_rst_n and wdt_timeout are already synchronous to clk.
module pwr_wake_arbiter
    import pwr_mode_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int IDW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  pm_state_e          state,
    input  logic               sleep_exec,
    input  logic               mode_sel,
    input  logic               wake_fall,
    input  logic               ext_rst_n,
    input  logic               wdt_timeout,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output pm_state_e          next_state,
    output wake_act_e          action,
    output logic [IDW-1:0]     pick_id
);

    logic [NUM_IRQ-1:0] armed;
    logic               restart;
    logic               any_req;
    logic               any_armed;

    assign armed     = irq_req & irq_en;
    assign restart   = ~ext_rst_n | wdt_timeout;
    assign any_req   = |irq_req;
    assign any_armed = |armed;

    // Lowest-index enabled and requested line.
    always_comb begin
        pick_id = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (armed[i]) pick_id = IDW'(i);
        end
    end

    // Next state and action, restart first.
    always_comb begin
        next_state = state;
        action     = WK_NONE;
        if (restart) begin
            next_state = PM_RUN;
            action     = WK_RESTART;
        end else begin
            unique case (state)
                PM_RUN: begin
                    if (sleep_exec) next_state = mode_sel ? PM_SLEEP : PM_IDLE;
                end
                PM_IDLE: begin
                    if (any_req) begin
                        next_state = PM_RUN;
                        action     = any_armed ? WK_SERVICE : WK_RESUME;
                    end
                end
                PM_SLEEP: begin
                    if (wake_fall) begin
                        next_state = PM_RUN;
                        action     = WK_RESUME;
                    end
                end
                default: begin
                    next_state = PM_RUN;
                    action     = WK_RESTART;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: pwr_mode_fsm
// Holds the power state and registers the one-cycle result pulses so that
// they line up with the cycle in which the state reads RUN again. Derives
// the clock and oscillator enables from the state and raises the watchdog
// clear strobe after power-on.
// Assumes: next_state and action come from pwr_wake_arbiter.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  pm_state_e      next_state,
    input  wake_act_e      action,
    input  logic [IDW-1:0] pick_id,
    output pm_state_e      state,
    output logic           core_clk_en,
    output logic           osc_en,
    output logic           periph_clk_en,
    output logic           reset_req,
    output logic           resume_next,
    output logic           irq_take,
    output logic [IDW-1:0] irq_id,
    output logic           wdt_clear
);

    pm_state_e      state_q;
    logic           rst_q, res_q, take_q, clr_q;
    logic [IDW-1:0] id_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= next_state;
    end

    // Result pulses, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            res_q  <= 1'b0;
            take_q <= 1'b0;
            id_q   <= '0;
        end else begin
            rst_q  <= (action == WK_RESTART);
            res_q  <= (action == WK_RESUME);
            take_q <= (action == WK_SERVICE);
            if (action == WK_SERVICE) id_q <= pick_id;
        end
    end

    // Watchdog clear: high through power-on reset, low after.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b1;
        else        clr_q <= 1'b0;
    end

    assign state         = state_q;
    assign core_clk_en   = (state_q == PM_RUN);
    assign osc_en        = (state_q != PM_SLEEP);
    assign periph_clk_en = (state_q != PM_SLEEP);
    assign reset_req     = rst_q;
    assign resume_next   = res_q;
    assign irq_take      = take_q;
    assign irq_id        = id_q;
    assign wdt_clear     = clr_q;

    // R12
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_q, res_q, take_q}));

    // R4
    resume_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_q |-> (state_q == PM_RUN));

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Power-mode sequencer: enters IDLE or SLEEP on the sleep strobe, watches
// the wake sources valid for the current depth and reports restart,
// resume-next or interrupt service.
// Assumes: rst_n, ext_rst_n, wdt_timeout, irq_* and sleep_exec are
// synchronous to clk; wake_pin_n may be asynchronous.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_IRQ     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDW        = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_exec,
    input  logic               mode_sel,
    input  logic               wake_pin_n,
    input  logic               ext_rst_n,
    input  logic               wdt_timeout,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               core_clk_en,
    output logic               osc_en,
    output logic               periph_clk_en,
    output logic               reset_req,
    output logic               resume_next,
    output logic               irq_take,
    output logic [IDW-1:0]     irq_id,
    output logic               wdt_clear,
    output logic [1:0]         mode_o
);

    logic           wake_fall;
    pm_state_e      state;
    pm_state_e      next_state;
    wake_act_e      action;
    logic [IDW-1:0] pick_id;

    pwr_wake_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (wake_pin_n),
        .fall  (wake_fall)
    );

    pwr_wake_arbiter #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) arb_i (
        .state       (state),
        .sleep_exec  (sleep_exec),
        .mode_sel    (mode_sel),
        .wake_fall   (wake_fall),
        .ext_rst_n   (ext_rst_n),
        .wdt_timeout (wdt_timeout),
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .next_state  (next_state),
        .action      (action),
        .pick_id     (pick_id)
    );

    pwr_mode_fsm #(.IDW(IDW)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .next_state    (next_state),
        .action        (action),
        .pick_id       (pick_id),
        .state         (state),
        .core_clk_en   (core_clk_en),
        .osc_en        (osc_en),
        .periph_clk_en (periph_clk_en),
        .reset_req     (reset_req),
        .resume_next   (resume_next),
        .irq_take      (irq_take),
        .irq_id        (irq_id),
        .wdt_clear     (wdt_clear)
    );

    assign mode_o = state;

    // R3
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && sleep_exec && mode_sel && ext_rst_n && !wdt_timeout)
        |=> (mode_o == 2'b10 && !osc_en));

    // R2
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && sleep_exec && !mode_sel && ext_rst_n && !wdt_timeout)
        |=> (mode_o == 2'b01 && osc_en && !core_clk_en));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rst_n || wdt_timeout) |=> (reset_req && mode_o == 2'b00));

    // R9
    sleep_irq_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_SLEEP && ext_rst_n && !wdt_timeout && !wake_fall)
        |=> (mode_o == 2'b10));

    // R7
    service_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(state == PM_IDLE));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
// Bench: scoreboard style. Driver tasks push the expected result pulse into
// a queue before causing it; a monitor pops and compares at every negedge
// on which a pulse appears. Static outputs are checked directly.
module pwr_mode_ctrl_tb_top;

    localparam int NI  = 4;
    localparam int IDW = 2;

    localparam int K_RST = 0;
    localparam int K_RES = 1;
    localparam int K_IRQ = 2;

    typedef struct {
        int    kind;
        int    id;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_exec = 1'b0;
    logic mode_sel = 1'b0;
    logic wake_pin_n = 1'b1;
    logic ext_rst_n = 1'b1;
    logic wdt_timeout = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic core_clk_en, osc_en, periph_clk_en;
    logic reset_req, resume_next, irq_take, wdt_clear;
    logic [IDW-1:0] irq_id;
    logic [1:0] mode_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    pwr_mode_ctrl #(.NUM_IRQ(NI), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .mode_sel(mode_sel),
        .wake_pin_n(wake_pin_n), .ext_rst_n(ext_rst_n), .wdt_timeout(wdt_timeout),
        .irq_req(irq_req), .irq_en(irq_en), .core_clk_en(core_clk_en),
        .osc_en(osc_en), .periph_clk_en(periph_clk_en), .reset_req(reset_req),
        .resume_next(resume_next), .irq_take(irq_take), .irq_id(irq_id),
        .wdt_clear(wdt_clear), .mode_o(mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_pulse(input int kind, input int id, input string req);
        exp_t e;
        e.kind = kind; e.id = id; e.req = req;
        sb.push_back(e);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Gates for a given mode: {core, osc, periph}.
    task automatic check_mode(input string req, input int m);
        check({req, " mode"}, mode_o, m);
        check({req, " gates"}, {core_clk_en, osc_en, periph_clk_en},
              (m == 0) ? 3'b111 : (m == 1) ? 3'b011 : 3'b000);
    endtask

    task automatic enter(input bit deep);
        sleep_exec = 1'b1; mode_sel = deep;
        cyc(1);
        sleep_exec = 1'b0; mode_sel = 1'b0;
    endtask

    // Monitor: compare every pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && (reset_req || resume_next || irq_take)) begin
            int kind;
            exp_t e;
            checks++;
            if ($countones({reset_req, resume_next, irq_take}) != 1) begin
                failures++;
                $display("FAIL R12 actual=%b expected=one-hot",
                         {reset_req, resume_next, irq_take});
            end
            kind = reset_req ? K_RST : resume_next ? K_RES : K_IRQ;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL unexpected pulse actual=%0d expected=none", kind);
            end else begin
                e = sb.pop_front();
                if (kind != e.kind || (kind == K_IRQ && int'(irq_id) != e.id)) begin
                    failures++;
                    $display("FAIL %s actual=%0d/%0d expected=%0d/%0d",
                             e.req, kind, irq_id, e.kind, e.id);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 / R11: reset state
        cyc(3);
        check_mode("R1", 0);
        check("R1 pulses", {reset_req, resume_next, irq_take}, 0);
        check("R11 clear in reset", wdt_clear, 1);
        rst_n = 1'b1;
        cyc(1);
        check("R11 clear released", wdt_clear, 0);

        // R2: idle entry
        enter(1'b0);
        check_mode("R2", 1);
        // R10: strobe in idle ignored
        enter(1'b1);
        cyc(1);
        check_mode("R10", 1);
        // R9: wake pin ignored in idle
        wake_pin_n = 1'b0;
        cyc(5);
        check_mode("R9 idle pin", 1);
        wake_pin_n = 1'b1;
        cyc(4);
        check_mode("R9 idle pin rise", 1);
        // R7: enabled interrupt, lowest armed index 1
        irq_req = 4'b1110; irq_en = 4'b1010;
        expect_pulse(K_IRQ, 1, "R7");
        cyc(1);
        check_mode("R7", 0);
        irq_req = '0;
        cyc(2);

        // R8: requested but not enabled
        enter(1'b0);
        irq_req = 4'b1000; irq_en = 4'b0111;
        expect_pulse(K_RES, 0, "R8");
        cyc(1);
        check_mode("R8", 0);
        irq_req = '0; irq_en = '0;
        cyc(2);

        // R3: deep sleep entry; R9: interrupts ignored
        enter(1'b1);
        check_mode("R3", 2);
        irq_req = 4'b0001; irq_en = 4'b0001;
        cyc(4);
        check_mode("R9 sleep irq", 2);
        irq_req = '0; irq_en = '0;
        // R4: wake pin falling edge, third edge
        wake_pin_n = 1'b0;
        cyc(2);
        check_mode("R4 not yet", 2);
        expect_pulse(K_RES, 0, "R4");
        cyc(1);
        check_mode("R4", 0);
        cyc(2);

        // R4: steady low pin does not wake
        enter(1'b1);
        cyc(5);
        check_mode("R4 level low", 2);
        wake_pin_n = 1'b1;
        cyc(5);
        check_mode("R4 rise", 2);

        // R6: watchdog coincides with detected wake edge
        wake_pin_n = 1'b0;
        cyc(2);
        wdt_timeout = 1'b1;
        expect_pulse(K_RST, 0, "R6");
        cyc(1);
        wdt_timeout = 1'b0;
        check_mode("R6", 0);
        cyc(3);
        wake_pin_n = 1'b1;
        cyc(3);

        // R5: reset pin in idle
        enter(1'b0);
        ext_rst_n = 1'b0;
        expect_pulse(K_RST, 0, "R5 pin");
        cyc(1);
        ext_rst_n = 1'b1;
        check_mode("R5 pin", 0);
        cyc(2);

        // R6: reset pin with sleep strobe in RUN
        sleep_exec = 1'b1; mode_sel = 1'b1; ext_rst_n = 1'b0;
        expect_pulse(K_RST, 0, "R6 strobe");
        cyc(1);
        sleep_exec = 1'b0; mode_sel = 1'b0; ext_rst_n = 1'b1;
        check_mode("R6 strobe", 0);
        cyc(2);

        // R5: watchdog in idle with an enabled interrupt pending
        enter(1'b0);
        irq_req = 4'b0100; irq_en = 4'b0100; wdt_timeout = 1'b1;
        expect_pulse(K_RST, 0, "R5 wdt");
        cyc(1);
        wdt_timeout = 1'b0; irq_req = '0; irq_en = '0;
        check_mode("R5 wdt", 0);
        cyc(3);

        check("scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule